// File: doc/BRIEF.md
# Per-Channel Pulse Time-Tag Ring Logger

This block keeps a history of the pulse events produced by one output channel. Each time the channel's trigger logic fires, the block captures a record. The record holds the free-running 96-bit timestamp as it stands on that clock cycle and 32 bits of event metadata. The metadata carries the measured output pulse length and a set of mode and status bits. Records go into a circular store of 256 entries. Once the store is full, every new event replaces the oldest record and raises a sticky overflow indication.

A bus bridge outside the block reads the history through a register-style port. It presents a record index, counted from the oldest record still held, and a word select, and one cycle later it receives one 16-bit word. The first six words form the fixed record view: two metadata words, then four timestamp words. Two extra word selects return the remaining upper timestamp bits. The block also reports how many records are valid. The overflow indication clears when the reader acknowledges it.

Top module: `tag_ring_logger`

## Requirements
- R1: After reset the entry count is 0, the overflow flag is 0, the read-valid strobe is 0 and the read data is 0.
- R2: A cycle with `fireStb` high stores one record, built from `timeStamp` and the metadata inputs sampled on that same edge. While fewer than 256 records are held, the entry count rises by one on that edge. It never exceeds 256 and does not change in cycles without `fireStb`.
- R3: A fire while 256 records are held replaces the oldest record. The count stays 256 and the overflow flag is set on that edge. Once set, the flag stays set until it is cleared.
- R4: A pulse on `ovfClr` clears the overflow flag on the next edge. If a fire into a full buffer happens in the same cycle, the set wins and the flag stays 1.
- R5: `rdIdx` counts from the oldest retained record, so index 0 is the oldest and index count-1 is the newest.
- R6: The word select picks a 16-bit word as follows. Word 0: bits 1:0 = input mode, bit 2 = short-pulse flag, bit 3 = long-pulse flag, bit 4 = input-OK, bits 9:8 = output mode, every other bit 0. Word 1: the pulse length in clock cycles. Words 2, 3, 4 and 5: timestamp bits 63:48, 47:32, 31:16 and 15:0. Word 6: timestamp bits 95:80. Word 7: timestamp bits 79:64.
- R7: A read issued with `rdEn` high on one edge drives `rdData` and raises `rdValid` after that edge, for exactly one cycle. Without `rdEn`, `rdValid` is 0 and `rdData` holds its value.
- R8: A read of the entry that a fire overwrites in the same cycle returns the record as it was before that write.
- R9: A read with `rdIdx` at or above the entry count returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fireStb | input | 1 | One-cycle pulse event strobe |
| timeStamp | input | 96 | Free-running timestamp |
| inMode | input | 2 | Input mode code stored in word 0 bits 1:0 |
| shortFlag | input | 1 | Short-pulse flag stored in word 0 bit 2 |
| longFlag | input | 1 | Long-pulse flag stored in word 0 bit 3 |
| inOk | input | 1 | Input-OK flag stored in word 0 bit 4 |
| outMode | input | 2 | Output mode code stored in word 0 bits 9:8 |
| pulseLen | input | 16 | Output pulse length in clock cycles |
| rdEn | input | 1 | Read request |
| rdIdx | input | 8 | Record index relative to the oldest record |
| rdWord | input | 3 | Word select within the record |
| ovfClr | input | 1 | Clears the overflow flag |
| rdData | output | 16 | Read word, valid the cycle after the request |
| rdValid | output | 1 | Read data strobe |
| entryCount | output | 9 | Number of valid records, 0 to 256 |
| overflow | output | 1 | Sticky overwrite indication |

## Verification
The table phase fires a handful of records whose timestamp and metadata fields all differ, then reads all eight words of each record. A wrong bit position, a swapped word order or a swapped timestamp half shows up as a mismatch on a specific word. A second phase fills the store past 256 events, with pulse lengths equal to the event number. The lengths read back from index 0 and index 255 then separate a correct oldest-relative index from a plain slot address, and a correct overwrite from a lost one. Directed cases cover the overflow clear and the clear-versus-set race. They also cover a same-cycle overwrite and read of the oldest slot, which must return the old record, and reads beyond the count, which must return zero.

// File: rtl/tag_log_pkg.sv
package tag_log_pkg;

  localparam int TS_W   = 96;
  localparam int WORD_W = 16;
  localparam int META_W = 2 * WORD_W;
  localparam int REC_W  = META_W + TS_W;
  localparam int TS_WORDS = TS_W / WORD_W;
  localparam int VIEW_WORDS = 2 + TS_WORDS;
  localparam int SEL_W  = $clog2(VIEW_WORDS);

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdHit;
  } logStrobes_t;

endpackage

// File: rtl/tag_log_ctrl.sv
module tag_log_ctrl
  import tag_log_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fireStb,
  input  logic          ovfClr,
  input  logic          rdEn,
  input  logic [AW-1:0] rdIdx,
  output logStrobes_t   strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW:0]   entryCount,
  output logic          overflow
);

  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [AW-1:0] wrPtr;
  logic [AW:0]   count;
  logic          ovfFlag;
  logic          isFull;
  logic [AW-1:0] oldest;

  assign isFull = (count == FULL_CNT);
  // when full the low bits of count are zero, so oldest equals wrPtr
  assign oldest = wrPtr - count[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (fireStb) begin
        wrPtr <= wrPtr + 1'b1;
        if (!isFull) count <= count + 1'b1;
      end
      if (fireStb && isFull)
        ovfFlag <= 1'b1;
      else if (ovfClr)
        ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.wrEn  = fireStb;
    strobes.rdEn  = rdEn;
    strobes.rdHit = ({1'b0, rdIdx} < count);
  end

  assign wrAddr     = wrPtr;
  assign rdAddr     = oldest + rdIdx;
  assign entryCount = count;
  assign overflow   = ovfFlag;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entryCount <= FULL_CNT);

  p_count_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fireStb && entryCount != FULL_CNT) |=> entryCount == $past(entryCount) + 1'b1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fireStb |=> $stable(entryCount));

  p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (entryCount == FULL_CNT) |=> entryCount == FULL_CNT);

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fireStb && entryCount == FULL_CNT) |=> overflow);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovfClr) |=> overflow);

  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfClr && !fireStb) |=> !overflow);

endmodule

// File: rtl/tag_log_data.sv
module tag_log_data
  import tag_log_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logStrobes_t       strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [SEL_W-1:0]  wordSel,
  input  logic [TS_W-1:0]   timeStamp,
  input  logic [1:0]        inMode,
  input  logic              shortFlag,
  input  logic              longFlag,
  input  logic              inOk,
  input  logic [1:0]        outMode,
  input  logic [WORD_W-1:0] pulseLen,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  logic [REC_W-1:0]  store [DEPTH];
  logic [REC_W-1:0]  wrRec;
  logic [REC_W-1:0]  rdRec;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] tsWord   [TS_WORDS];
  logic [WORD_W-1:0] viewWord [VIEW_WORDS];

  always_comb begin
    statusWord      = '0;
    statusWord[1:0] = inMode;
    statusWord[2]   = shortFlag;
    statusWord[3]   = longFlag;
    statusWord[4]   = inOk;
    statusWord[9:8] = outMode;
  end

  assign wrRec = {statusWord, pulseLen, timeStamp};

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= wrRec;
  end

  assign rdRec = store[rdAddr];

  genvar g;
  generate
    for (g = 0; g < TS_WORDS; g++) begin : g_tsSplit
      assign tsWord[g] = rdRec[g*WORD_W +: WORD_W];
    end
  endgenerate

  // view: status, length, low four timestamp words high to low, then the upper two
  assign viewWord[0] = rdRec[REC_W-1 -: WORD_W];
  assign viewWord[1] = rdRec[REC_W-WORD_W-1 -: WORD_W];
  generate
    for (g = 0; g < 4; g++) begin : g_lowView
      assign viewWord[2+g] = tsWord[3-g];
    end
    for (g = 4; g < TS_WORDS; g++) begin : g_highView
      assign viewWord[2+g] = tsWord[TS_WORDS+3-g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn)
        rdData <= strobes.rdHit ? viewWord[wordSel] : '0;
    end
  end

  p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdEn |=> rdValid);

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rdEn |=> (!rdValid && $stable(rdData)));

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rdEn && !strobes.rdHit) |=> rdData == '0);

endmodule

// File: rtl/tag_ring_logger.sv
module tag_ring_logger
  import tag_log_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fireStb,
  input  logic [TS_W-1:0]   timeStamp,
  input  logic [1:0]        inMode,
  input  logic              shortFlag,
  input  logic              longFlag,
  input  logic              inOk,
  input  logic [1:0]        outMode,
  input  logic [WORD_W-1:0] pulseLen,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdIdx,
  input  logic [SEL_W-1:0]  rdWord,
  input  logic              ovfClr,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic [AW:0]       entryCount,
  output logic              overflow
);

  logStrobes_t   strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  tag_log_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fireStb    (fireStb),
    .ovfClr     (ovfClr),
    .rdEn       (rdEn),
    .rdIdx      (rdIdx),
    .strobes    (strobes),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .entryCount (entryCount),
    .overflow   (overflow)
  );

  tag_log_data #(.DEPTH(DEPTH)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .wordSel   (rdWord),
    .timeStamp (timeStamp),
    .inMode    (inMode),
    .shortFlag (shortFlag),
    .longFlag  (longFlag),
    .inOk      (inOk),
    .outMode   (outMode),
    .pulseLen  (pulseLen),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: tb/tag_ring_logger_tb.sv
module tag_ring_logger_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fireStb = 1'b0;
  logic [95:0] timeStamp = '0;
  logic [1:0]  inMode = '0;
  logic        shortFlag = 1'b0;
  logic        longFlag = 1'b0;
  logic        inOk = 1'b0;
  logic [1:0]  outMode = '0;
  logic [15:0] pulseLen = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdIdx = '0;
  logic [2:0]  rdWord = '0;
  logic        ovfClr = 1'b0;
  logic [15:0] rdData;
  logic        rdValid;
  logic [8:0]  entryCount;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  int nFired = 0;
  logic [15:0] got;

  always #2 clk = ~clk;

  tag_ring_logger u_dut (
    .clk(clk), .rst_n(rst_n), .fireStb(fireStb), .timeStamp(timeStamp),
    .inMode(inMode), .shortFlag(shortFlag), .longFlag(longFlag), .inOk(inOk),
    .outMode(outMode), .pulseLen(pulseLen), .rdEn(rdEn), .rdIdx(rdIdx),
    .rdWord(rdWord), .ovfClr(ovfClr), .rdData(rdData), .rdValid(rdValid),
    .entryCount(entryCount), .overflow(overflow)
  );

  // stimulus table: timestamp, input mode, short, long, ok, output mode, length
  localparam int NROW = 5;
  localparam logic [95:0] T_TS [NROW] = '{
    96'h0123_4567_89AB_CDEF_0011_2233, 96'hFFFF_0000_1234_5678_9ABC_DEF0,
    96'h0000_0000_0000_0000_0000_0001, 96'h8000_7FFF_A5A5_5A5A_F00F_0FF0,
    96'hDEAD_BEEF_CAFE_F00D_1357_2468 };
  localparam logic [1:0]  T_IM  [NROW] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2};
  localparam logic        T_SH  [NROW] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        T_LG  [NROW] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        T_OK  [NROW] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [1:0]  T_OM  [NROW] = '{2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [15:0] T_LEN [NROW] = '{16'd12, 16'd300, 16'hFFFF, 16'd0, 16'd77};

  function automatic logic [15:0] expWord(input logic [95:0] ts, input logic [1:0] im,
      input logic sh, input logic lg, input logic ok, input logic [1:0] om,
      input logic [15:0] len, input int w);
    case (w)
      0: return {6'b0, om, 3'b0, ok, lg, sh, im};
      1: return len;
      2: return ts[63:48];
      3: return ts[47:32];
      4: return ts[31:16];
      5: return ts[15:0];
      6: return ts[95:80];
      default: return ts[79:64];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nFired = 0;
  endtask

  task automatic fire(input logic [95:0] ts, input logic [1:0] im, input logic sh,
      input logic lg, input logic ok, input logic [1:0] om, input logic [15:0] len);
    @(negedge clk);
    fireStb = 1'b1; timeStamp = ts; inMode = im; shortFlag = sh;
    longFlag = lg; inOk = ok; outMode = om; pulseLen = len;
    @(negedge clk);
    fireStb = 1'b0;
    nFired++;
  endtask

  task automatic fireLen(input int n);
    fire({32'hA5A5_0000, 64'(1000 + n)}, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 16'(n));
  endtask

  // issues a read and samples at the following falling edge
  task automatic readWord(input int idx, input int w, output logic [15:0] data);
    @(negedge clk);
    rdEn = 1'b1; rdIdx = 8'(idx); rdWord = 3'(w);
    @(negedge clk);
    rdEn = 1'b0;
    data = rdData;
    check(rdValid === 1'b1, "R7 rdValid after read", 32'(rdValid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check(entryCount === 9'd0, "R1 count", 32'(entryCount), 0);
    check(overflow === 1'b0, "R1 overflow", 32'(overflow), 0);
    check(rdValid === 1'b0, "R1 rdValid", 32'(rdValid), 0);
    check(rdData === 16'd0, "R1 rdData", 32'(rdData), 0);

    // table phase: capture records, read all words (R2, R5, R6)
    for (int r = 0; r < NROW; r++) begin
      fire(T_TS[r], T_IM[r], T_SH[r], T_LG[r], T_OK[r], T_OM[r], T_LEN[r]);
      check(entryCount === 9'(r + 1), "R2 count increments", 32'(entryCount), r + 1);
    end
    for (int r = 0; r < NROW; r++) begin
      for (int w = 0; w < 8; w++) begin
        logic [15:0] e;
        e = expWord(T_TS[r], T_IM[r], T_SH[r], T_LG[r], T_OK[r], T_OM[r], T_LEN[r], w);
        readWord(r, w, got);
        check(got === e, "R6 word layout", 32'(got), 32'(e));
      end
    end
    // R7: rdData holds and rdValid drops with no request
    @(negedge clk);
    check(rdValid === 1'b0, "R7 rdValid idle", 32'(rdValid), 0);
    check(rdData === expWord(T_TS[4], T_IM[4], T_SH[4], T_LG[4], T_OK[4], T_OM[4], T_LEN[4], 7),
          "R7 rdData hold", 32'(rdData), 32'(T_TS[4][79:64]));
    // R2: count stable without fire
    check(entryCount === 9'd5, "R2 count hold", 32'(entryCount), 5);
    // R9: reads beyond the count give zero
    readWord(5, 1, got);
    check(got === 16'd0, "R9 index at count", 32'(got), 0);
    readWord(200, 3, got);
    check(got === 16'd0, "R9 index above count", 32'(got), 0);

    // fill past capacity (R3, R5)
    doReset();
    for (int n = 0; n < 258; n++) begin
      fireLen(n);
      if (n == 255) begin
        check(entryCount === 9'd256, "R2 count reaches 256", 32'(entryCount), 256);
        check(overflow === 1'b0, "R3 no overflow at exact fill", 32'(overflow), 0);
      end
    end
    check(entryCount === 9'd256, "R3 count stays 256", 32'(entryCount), 256);
    check(overflow === 1'b1, "R3 overflow set", 32'(overflow), 1);
    readWord(0, 1, got);
    check(got === 16'd2, "R5 index 0 is oldest", 32'(got), 2);
    readWord(255, 1, got);
    check(got === 16'd257, "R5 index 255 is newest", 32'(got), 257);
    readWord(0, 5, got);
    check(got === 16'd1002, "R3 R6 timestamp of oldest", 32'(got), 1002);
    readWord(255, 6, got);
    check(got === 16'hA5A5, "R6 upper timestamp word", 32'(got), 16'hA5A5);
    @(negedge clk);
    check(overflow === 1'b1, "R3 overflow sticky", 32'(overflow), 1);

    // R4: clear, then set wins over clear
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    check(overflow === 1'b0, "R4 overflow cleared", 32'(overflow), 0);
    @(negedge clk); ovfClr = 1'b1;
    fireLen(nFired);
    ovfClr = 1'b0;
    check(overflow === 1'b1, "R4 set wins over clear", 32'(overflow), 1);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    check(overflow === 1'b0, "R4 cleared again", 32'(overflow), 0);

    // R8: overwrite and read of the oldest slot in the same cycle
    begin
      int oldLen;
      oldLen = nFired - 256;
      @(negedge clk);
      fireStb = 1'b1; timeStamp = {32'hA5A5_0000, 64'(1000 + nFired)};
      pulseLen = 16'(nFired);
      rdEn = 1'b1; rdIdx = 8'd0; rdWord = 3'd1;
      @(negedge clk);
      fireStb = 1'b0; rdEn = 1'b0;
      check(rdData === 16'(oldLen), "R8 same-cycle read returns old", 32'(rdData), oldLen);
      readWord(255, 1, got);
      check(got === 16'(nFired), "R8 new record stored", 32'(got), nFired);
      nFired++;
      readWord(0, 1, got);
      check(got === 16'(oldLen + 1), "R3 R5 oldest advanced", 32'(got), oldLen + 1);
      check(overflow === 1'b1, "R3 overflow on overwrite", 32'(overflow), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule